// File: doc/BRIEF.md
# Autoincrement Shadow Register Bank with Commit

This block sits beside the general register file of a sequential operand decoder. Operand specifiers arrive one per cycle, from left to right. Each one carries a register number, a flag saying whether the mode post-increments the register, and a size code. The block returns the register value that the operand must use. For a post-increment specifier, it also computes the register value plus the operand size. That sum goes to a temporary bank and not to the general registers.

A per-register pending bit records which general registers have a newer value waiting in the temporary bank. A later specifier in the same instruction that names such a register is served from the temporary copy. As a result, chained post-increments of one register each see the result of the use before them. At instruction end the sequencer spends one cycle finishing and pulses `done`. If no exception was flagged, the pending temporaries are copied into the general registers. If an exception was flagged, they are dropped. In both cases every pending bit clears, and the block accepts no specifier and no register write during that cycle.

Top module: `autoinc_shadow`

## Requirements
- R1: After reset all general registers read zero, no register is pending, `spec_ready` is 1 and `done` is 0.
- R2: A specifier with `spec_autoinc`=0 on a register with nothing pending returns the general register value on `opnd_value` in the same cycle, with `opnd_hit`=0, and leaves that register not pending.
- R3: A post-increment specifier returns the pre-increment value and makes the register pending with value plus size. The size codes on `spec_size` are 0=1 byte, 1=2 bytes, 2=4 bytes and 3=8 bytes.
- R4: A specifier that names a pending register reads the temporary copy, with `opnd_hit`=1. Three 4-byte post-increments of one register starting from x return x, x+4 and x+8.
- R5: While values are pending, `rd_data` keeps returning the unchanged general register value.
- R6: `instr_end` with `instr_exc`=0 while idle gives `done`=1 in the following cycle. From the cycle after that, each pending register holds its temporary value.
- R7: `instr_end` with `instr_exc`=1 also gives `done` one cycle later, but no general register changes.
- R8: After `done`, no register is pending: a specifier on a previously pending register returns the general value with `opnd_hit`=0.
- R9: During the `done` cycle `spec_ready` is 0, and a specifier presented then has no effect.
- R10: Increments wrap modulo 2^XLEN.
- R11: A general register write (`wr_en`) takes effect only when `spec_ready` is 1. It is ignored during the `done` cycle.
- R12: A post-increment specifier accepted in the same cycle as `instr_end` is included in that instruction's commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spec_valid | input | 1 | Operand specifier present |
| spec_reg | input | $clog2(NREG) | Register named by the specifier |
| spec_autoinc | input | 1 | 1 = post-increment mode |
| spec_size | input | 2 | Operand size code (0:1, 1:2, 2:4, 3:8 bytes) |
| spec_ready | output | 1 | Specifiers and writes accepted |
| opnd_value | output | XLEN | Register value seen by this operand |
| opnd_hit | output | 1 | Value came from the temporary bank |
| instr_end | input | 1 | Instruction end request |
| instr_exc | input | 1 | Exception flag qualifying `instr_end` |
| done | output | 1 | One-cycle commit/abort pulse |
| wr_en | input | 1 | General register write enable |
| wr_reg | input | $clog2(NREG) | General register write index |
| wr_data | input | XLEN | General register write data |
| rd_reg | input | $clog2(NREG) | General register read index |
| rd_data | output | XLEN | General register read data (architectural only) |

## Verification
The bench builds the block with its defaults, 16 registers of 32 bits. That is enough for two registers to hold interleaved pending chains with all four size codes, and for a value near 2^32 to show the increment wrapping. The full 32-bit width keeps the pre-increment and temporary values easy to tell apart. A specifier and register write aimed into the `done` cycle, and a specifier coinciding with `instr_end`, exercise the two cycle-level boundaries of the handshake.

// File: rtl/ais_pkg.sv
// Shared types for the autoincrement shadow bank.
// Assumes the size code is two bits wide and the byte count is a power of two.
package ais_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_LONG = 2'd2,
        SZ_QUAD = 2'd3
    } size_e;

    typedef enum logic {
        SQ_IDLE   = 1'b0,
        SQ_FINISH = 1'b1
    } seq_e;

    // Byte count that goes with a size code.
    function automatic logic [3:0] size_bytes(input size_e s);
        return 4'd1 << s;
    endfunction

endpackage

// File: rtl/ais_seq.sv
// Instruction-end sequencer. It latches an end request and its exception flag
// while idle, then spends one cycle finishing.
// Assumes instr_end is only acted on while idle.
module ais_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic instr_end,
    input  logic instr_exc,
    output logic ready,
    output logic finish,
    output logic commit_en
);
    import ais_pkg::*;

    seq_e state_q;
    logic exc_q;

    // State and exception flag register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            exc_q   <= 1'b0;
        end else if (state_q == SQ_IDLE) begin
            if (instr_end) begin
                state_q <= SQ_FINISH;
                exc_q   <= instr_exc;
            end
        end else begin
            state_q <= SQ_IDLE;
            exc_q   <= 1'b0;
        end
    end

    // Decoded outputs.
    always_comb begin
        ready     = (state_q == SQ_IDLE);
        finish    = (state_q == SQ_FINISH);
        commit_en = finish && !exc_q;
    end

endmodule

// File: rtl/ais_temp_bank.sv
// Temporary bank with pending bits and same-register forwarding.
// It serves a specifier from its temporary copy when one is pending, and
// records base plus size for post-increment specifiers.
// Assumes acc and clear are never high together.
module ais_temp_bank #(
    parameter int NREG = 16,
    parameter int XLEN = 32,
    localparam int RW  = $clog2(NREG)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 acc,
    input  logic [RW-1:0]        sel,
    input  logic [1:0]           size,
    input  logic [XLEN-1:0]      gpr_val,
    input  logic                 clear,
    output logic [XLEN-1:0]      base,
    output logic                 hit,
    output logic [NREG-1:0]      pend_mask,
    output logic [NREG*XLEN-1:0] temp_flat
);
    import ais_pkg::*;

    logic [XLEN-1:0] temp_q [NREG];
    logic [NREG-1:0] pend_q;
    logic [XLEN-1:0] next_val;

    // Forwarding comparator and incrementer.
    always_comb begin
        hit      = pend_q[sel];
        base     = hit ? temp_q[sel] : gpr_val;
        next_val = base + XLEN'(size_bytes(size_e'(size)));
    end

    for (genvar i = 0; i < NREG; i++) begin : g_slot
        // One temporary entry with its pending bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                temp_q[i] <= '0;
                pend_q[i] <= 1'b0;
            end else if (clear) begin
                pend_q[i] <= 1'b0;
            end else if (acc && sel == RW'(i)) begin
                temp_q[i] <= next_val;
                pend_q[i] <= 1'b1;
            end
        end
        assign temp_flat[i*XLEN +: XLEN] = temp_q[i];
    end

    assign pend_mask = pend_q;

endmodule

// File: rtl/ais_gpr_bank.sv
// General register bank with one write port, a parallel commit from the
// temporary bank, and two read ports.
// Assumes wr_en and commit_en are never high together.
module ais_gpr_bank #(
    parameter int NREG = 16,
    parameter int XLEN = 32,
    localparam int RW  = $clog2(NREG)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [RW-1:0]        wr_reg,
    input  logic [XLEN-1:0]      wr_data,
    input  logic                 commit_en,
    input  logic [NREG-1:0]      pend_mask,
    input  logic [NREG*XLEN-1:0] temp_flat,
    input  logic [RW-1:0]        sel,
    output logic [XLEN-1:0]      sel_val,
    input  logic [RW-1:0]        rd_reg,
    output logic [XLEN-1:0]      rd_data,
    output logic [NREG*XLEN-1:0] gpr_flat
);
    logic [XLEN-1:0] gpr_q [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        // One general register: commit or write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                gpr_q[i] <= '0;
            end else if (commit_en && pend_mask[i]) begin
                gpr_q[i] <= temp_flat[i*XLEN +: XLEN];
            end else if (wr_en && wr_reg == RW'(i)) begin
                gpr_q[i] <= wr_data;
            end
        end
        assign gpr_flat[i*XLEN +: XLEN] = gpr_q[i];
    end

    // Read ports.
    always_comb begin
        sel_val = gpr_q[sel];
        rd_data = gpr_q[rd_reg];
    end

endmodule

// File: rtl/autoinc_shadow.sv
// Top: autoincrement shadow bank with commit or discard at instruction end.
// Assumes one specifier per cycle, issued in left-to-right operand order.
module autoinc_shadow #(
    parameter int NREG = 16,
    parameter int XLEN = 32,
    localparam int RW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            spec_valid,
    input  logic [RW-1:0]   spec_reg,
    input  logic            spec_autoinc,
    input  logic [1:0]      spec_size,
    output logic            spec_ready,
    output logic [XLEN-1:0] opnd_value,
    output logic            opnd_hit,
    input  logic            instr_end,
    input  logic            instr_exc,
    output logic            done,
    input  logic            wr_en,
    input  logic [RW-1:0]   wr_reg,
    input  logic [XLEN-1:0] wr_data,
    input  logic [RW-1:0]   rd_reg,
    output logic [XLEN-1:0] rd_data
);
    logic                 commit_en;
    logic                 acc;
    logic                 wr_ok;
    logic [XLEN-1:0]      sel_val;
    logic [NREG-1:0]      pend_mask;
    logic [NREG*XLEN-1:0] temp_flat;
    logic [NREG*XLEN-1:0] gpr_flat;

    // Gate specifier and write acceptance with the idle state.
    always_comb begin
        acc   = spec_valid && spec_autoinc && spec_ready;
        wr_ok = wr_en && spec_ready;
    end

    ais_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .instr_end (instr_end),
        .instr_exc (instr_exc),
        .ready     (spec_ready),
        .finish    (done),
        .commit_en (commit_en)
    );

    ais_temp_bank #(.NREG(NREG), .XLEN(XLEN)) u_temp (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc       (acc),
        .sel       (spec_reg),
        .size      (spec_size),
        .gpr_val   (sel_val),
        .clear     (done),
        .base      (opnd_value),
        .hit       (opnd_hit),
        .pend_mask (pend_mask),
        .temp_flat (temp_flat)
    );

    ais_gpr_bank #(.NREG(NREG), .XLEN(XLEN)) u_gpr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_ok),
        .wr_reg    (wr_reg),
        .wr_data   (wr_data),
        .commit_en (commit_en),
        .pend_mask (pend_mask),
        .temp_flat (temp_flat),
        .sel       (spec_reg),
        .sel_val   (sel_val),
        .rd_reg    (rd_reg),
        .rd_data   (rd_data),
        .gpr_flat  (gpr_flat)
    );

endmodule

// File: rtl/ais_chk.sv
// Checker for autoinc_shadow, bound to every instance of the top.
module ais_chk #(
    parameter int NREG = 16,
    parameter int XLEN = 32,
    localparam int RW  = $clog2(NREG)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 spec_valid,
    input logic [RW-1:0]        spec_reg,
    input logic                 spec_autoinc,
    input logic                 spec_ready,
    input logic                 instr_end,
    input logic                 done,
    input logic                 wr_en,
    input logic [NREG-1:0]      pend_mask,
    input logic [NREG*XLEN-1:0] gpr_flat
);
    AST_END_GIVES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_end && spec_ready) |=> done);                          // R6
    AST_DONE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !spec_ready);                                        // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                              // R7
    AST_PEND_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (pend_mask == '0));                                  // R8
    AST_AUTOINC_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (spec_valid && spec_autoinc && spec_ready) |=> pend_mask[$past(spec_reg)]); // R3
    AST_GPR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && !(wr_en && spec_ready)) |=> $stable(gpr_flat));     // R5
endmodule

bind autoinc_shadow ais_chk #(.NREG(NREG), .XLEN(XLEN)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .spec_valid   (spec_valid),
    .spec_reg     (spec_reg),
    .spec_autoinc (spec_autoinc),
    .spec_ready   (spec_ready),
    .instr_end    (instr_end),
    .done         (done),
    .wr_en        (wr_en),
    .pend_mask    (pend_mask),
    .gpr_flat     (gpr_flat)
);

// File: tb/autoinc_shadow_tb.sv
module autoinc_shadow_tb;
    localparam int NREG = 16;
    localparam int XLEN = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            spec_valid = 1'b0;
    logic [3:0]      spec_reg = '0;
    logic            spec_autoinc = 1'b0;
    logic [1:0]      spec_size = '0;
    logic            spec_ready;
    logic [XLEN-1:0] opnd_value;
    logic            opnd_hit;
    logic            instr_end = 1'b0;
    logic            instr_exc = 1'b0;
    logic            done;
    logic            wr_en = 1'b0;
    logic [3:0]      wr_reg = '0;
    logic [XLEN-1:0] wr_data = '0;
    logic [3:0]      rd_reg = '0;
    logic [XLEN-1:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    autoinc_shadow #(.NREG(NREG), .XLEN(XLEN)) u_dut (.*);

    // Vector: {reg[39:36], autoinc[35], size[34:33], hit[32], value[31:0]}
    localparam logic [39:0] VEC [8] = '{
        {4'd2, 1'b1, 2'd2, 1'b0, 32'h0000_0100},  // R3
        {4'd2, 1'b1, 2'd2, 1'b1, 32'h0000_0104},  // R4
        {4'd2, 1'b1, 2'd2, 1'b1, 32'h0000_0108},  // R4
        {4'd5, 1'b0, 2'd0, 1'b0, 32'h0000_2000},  // R2
        {4'd5, 1'b1, 2'd0, 1'b0, 32'h0000_2000},  // R3 size 1
        {4'd5, 1'b1, 2'd1, 1'b1, 32'h0000_2001},  // R3 size 2
        {4'd5, 1'b1, 2'd3, 1'b1, 32'h0000_2003},  // R3 size 8
        {4'd5, 1'b0, 2'd0, 1'b1, 32'h0000_200B}   // R4
    };

    task automatic check(input bit ok, input string req, input logic [XLEN-1:0] act,
                         input logic [XLEN-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic gpr_write(input logic [3:0] r, input logic [XLEN-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_reg = r; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic gpr_check(input logic [3:0] r, input logic [XLEN-1:0] exp, input string req);
        @(negedge clk);
        rd_reg = r;
        #1;
        check(rd_data == exp, req, rd_data, exp);
    endtask

    task automatic spec(input logic [3:0] r, input bit ai, input logic [1:0] sz,
                        input bit exp_hit, input logic [XLEN-1:0] exp_val, input string req);
        @(negedge clk);
        spec_valid = 1'b1; spec_reg = r; spec_autoinc = ai; spec_size = sz;
        #1;
        check(opnd_value == exp_val, req, opnd_value, exp_val);
        check(opnd_hit == exp_hit, req, XLEN'(opnd_hit), XLEN'(exp_hit));
        @(posedge clk); #1;
        spec_valid = 1'b0; spec_autoinc = 1'b0;
    endtask

    task automatic end_instr(input bit exc, input string req);
        @(negedge clk);
        instr_end = 1'b1; instr_exc = exc;
        @(posedge clk); #1;
        instr_end = 1'b0; instr_exc = 1'b0;
        @(negedge clk);
        check(done == 1'b1, req, XLEN'(done), 1);
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        check(spec_ready == 1'b1, "R1", XLEN'(spec_ready), 1);
        check(done == 1'b0, "R1", XLEN'(done), 0);
        for (int i = 0; i < NREG; i++) gpr_check(4'(i), 0, "R1");

        gpr_write(4'd2, 32'h100);
        gpr_write(4'd5, 32'h2000);

        for (int k = 0; k < 8; k++)
            spec(VEC[k][39:36], VEC[k][35], VEC[k][34:33], VEC[k][32], VEC[k][31:0], "R2/R3/R4 vector");

        gpr_check(4'd2, 32'h100, "R5");
        gpr_check(4'd5, 32'h2000, "R5");
        end_instr(1'b0, "R6");
        gpr_check(4'd2, 32'h10C, "R6");
        gpr_check(4'd5, 32'h200B, "R6");
        spec(4'd2, 1'b0, 2'd0, 1'b0, 32'h10C, "R8");

        // R7: exception discards
        spec(4'd2, 1'b1, 2'd3, 1'b0, 32'h10C, "R7");
        spec(4'd2, 1'b0, 2'd0, 1'b1, 32'h114, "R7");
        end_instr(1'b1, "R7");
        gpr_check(4'd2, 32'h10C, "R7");
        spec(4'd2, 1'b0, 2'd0, 1'b0, 32'h10C, "R8");

        // R10: wrap
        gpr_write(4'd7, 32'hFFFF_FFFE);
        spec(4'd7, 1'b1, 2'd2, 1'b0, 32'hFFFF_FFFE, "R10");
        spec(4'd7, 1'b0, 2'd0, 1'b1, 32'h2, "R10");
        end_instr(1'b0, "R10");
        gpr_check(4'd7, 32'h2, "R10");

        // R9/R11: specifier and write during the done cycle are ignored
        @(negedge clk);
        instr_end = 1'b1;
        @(posedge clk); #1;
        instr_end = 1'b0;
        spec_valid = 1'b1; spec_reg = 4'd3; spec_autoinc = 1'b1; spec_size = 2'd2;
        wr_en = 1'b1; wr_reg = 4'd3; wr_data = 32'h55;
        @(negedge clk);
        check(spec_ready == 1'b0, "R9", XLEN'(spec_ready), 0);
        @(posedge clk); #1;
        spec_valid = 1'b0; spec_autoinc = 1'b0; wr_en = 1'b0;
        gpr_check(4'd3, 0, "R11");
        spec(4'd3, 1'b0, 2'd0, 1'b0, 0, "R9");

        // R12: specifier in the same cycle as instr_end
        @(negedge clk);
        spec_valid = 1'b1; spec_reg = 4'd4; spec_autoinc = 1'b1; spec_size = 2'd3;
        instr_end = 1'b1;
        @(posedge clk); #1;
        spec_valid = 1'b0; spec_autoinc = 1'b0; instr_end = 1'b0;
        @(negedge clk);
        check(done == 1'b1, "R12", XLEN'(done), 1);
        @(posedge clk); #1;
        gpr_check(4'd4, 32'h8, "R12");

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule